// File: doc/BRIEF.md
# Bundle Issue-Group Former

This block sits between bundle fetch and the issue stage of a statically scheduled core. It takes a stream of 128-bit instruction bundles over a valid/ready handshake. Each bundle holds three 41-bit instructions and a 5-bit template. Bit 0 of the template is an end-of-group mark set by the compiler. The block checks no dependencies between instructions: every instruction inside one group is treated as independent. The group boundaries come only from that mark, and a group may chain through any number of bundles.

Accepted bundles collect in a two-bundle window. The window is presented to the issue port as one packet of six lanes. Each lane carries the instruction, its unit class and a valid or illegal flag. A packet closes in three cases: the bundle just taken carries the end mark, the window holds two bundles, or the two bundles together would need more execution units of one class than a cycle provides. In the last case only the first bundle is issued. The second bundle is carried into the next packet, and a one-cycle overflow pulse is raised.

Top module: `igf_issue_former`

## Requirements
- R1: Slot k of a bundle sits at bits [5+41k+40 : 5+41k], with the template in bits [4:0]. Slot k of the first issued bundle appears on lane k, and slot k of the second appears on lane 3+k, each lane owning bits [41L+40 : 41L] of `iss_instr`.
- R2: The class is the 4-bit field at bits [40:37] of an instruction: 0 integer, 1 load, 2 store, 3 floating point, 4 branch. A legal lane shows the low three bits of that code on `iss_cls[3L+2:3L]`.
- R3: A class code of 5 to 15 is illegal. That lane has `iss_lane_ill` set, `iss_lane_vld` clear, and zero instruction and class bits. A lane is never both valid and illegal.
- R4: A bundle with template bit 0 set closes the group. The packet that holds it is presented with `iss_grp_end` high.
- R5: A bundle with template bit 0 clear continues the group into the following bundle. A chain of more than two bundles is issued as successive packets with `iss_grp_end` low until the marked bundle.
- R6: A packet holds at most two bundles. Lanes of a bundle that is not part of the packet are all zero.
- R7: A two-bundle packet never needs more than 2 integer, 2 load, 2 store, 4 floating-point or 3 branch units, counting legal lanes only. If pairing would exceed any of these limits, the first bundle is issued alone with `iss_grp_end` low, and the second leads the next packet.
- R8: `cap_ovf` is high for exactly the one cycle after the edge that accepts a bundle whose pairing broke a limit, and low otherwise.
- R9: A bundle issued alone is issued whole even if its own three slots exceed a limit.
- R10: `in_ready` equals `iss_ready` while no packet is waiting, and is low while a packet is waiting. A waiting packet stays stable until taken. Bundles leave in arrival order, none lost or repeated.
- R11: During reset `iss_valid` and `cap_ovf` are low, and the window is empty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A bundle is offered |
| in_ready | output | 1 | The block takes the offered bundle |
| in_bundle | input | 128 | Bundle: template and three instruction slots |
| iss_valid | output | 1 | A packet is presented to the issue stage |
| iss_ready | input | 1 | The issue stage takes the packet |
| iss_lane_vld | output | 6 | Per lane: legal instruction present |
| iss_lane_ill | output | 6 | Per lane: illegal class, issued as a no-op |
| iss_instr | output | 246 | Six 41-bit lane instructions |
| iss_cls | output | 18 | Six 3-bit lane unit classes |
| iss_grp_end | output | 1 | This packet ends the issue group |
| cap_ovf | output | 1 | One-cycle pulse: a unit limit forced a split |

## Verification
A packet becomes visible in the cycle after the rising edge that accepts the bundle closing it. It stays until the edge where `iss_ready` is seen high. `cap_ovf` rises in the cycle right after the accepting edge and lasts one cycle. The bench drives inputs just after each falling edge and samples the handshake and the packet contents 1 ns later, before the next rising edge. It compares `cap_ovf` at the following falling edge against the split that its own model predicted for the bundle accepted one edge earlier. Expected packets come from a transaction-level queue built when each bundle is accepted, so the comparison does not depend on latency beyond that one register stage.

// File: rtl/igf_pkg.sv
package igf_pkg;
   localparam int CNT_W   = 4;
   localparam int CLS_W   = 3;
   localparam int NUM_CLS = 5;

   typedef enum logic [CLS_W-1:0] {
      UC_INT = 3'd0,
      UC_LD  = 3'd1,
      UC_ST  = 3'd2,
      UC_FP  = 3'd3,
      UC_BR  = 3'd4
   } ucls_e;

   typedef struct packed {
      logic [CNT_W-1:0] br;
      logic [CNT_W-1:0] fp;
      logic [CNT_W-1:0] st;
      logic [CNT_W-1:0] ld;
      logic [CNT_W-1:0] intg;
   } ucnt_t;
endpackage

// File: rtl/igf_bundle_decode.sv
module igf_bundle_decode import igf_pkg::*; #(
   parameter int SLOTS        = 3,
   parameter int INSTR_W      = 41,
   parameter int TMPL_W       = 5,
   parameter int CLS_LSB      = 37,
   parameter int CLS_FW       = 4,
   parameter int EOB_BIT      = 0,
   parameter int ZERO_ILLEGAL = 1,
   localparam int BUNDLE_W    = TMPL_W + SLOTS*INSTR_W
) (
   input  logic [BUNDLE_W-1:0]      bundle_i,
   output logic                     eob_o,
   output logic [SLOTS-1:0]         legal_o,
   output logic [SLOTS*CLS_W-1:0]   cls_o,
   output logic [SLOTS*INSTR_W-1:0] instr_o,
   output ucnt_t                    cnt_o
);
   logic unused_tmpl;
   assign unused_tmpl = ^bundle_i[TMPL_W-1:0];

   // R4/R5: group mark in the template
   assign eob_o = bundle_i[EOB_BIT];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [INSTR_W-1:0] raw;
      logic [CLS_FW-1:0]  code;
      assign raw  = bundle_i[TMPL_W + s*INSTR_W +: INSTR_W];   // R1
      assign code = raw[CLS_LSB +: CLS_FW];                     // R2
      assign legal_o[s] = (code < CLS_FW'(NUM_CLS));            // R3
      assign cls_o[s*CLS_W +: CLS_W] = legal_o[s] ? code[CLS_W-1:0] : '0;
      if (ZERO_ILLEGAL != 0) begin : g_zero
         assign instr_o[s*INSTR_W +: INSTR_W] = legal_o[s] ? raw : '0;
      end else begin : g_pass
         assign instr_o[s*INSTR_W +: INSTR_W] = raw;
      end
   end

   always_comb begin
      cnt_o = '0;
      for (int s = 0; s < SLOTS; s++) begin
         if (legal_o[s]) begin
            case (ucls_e'(cls_o[s*CLS_W +: CLS_W]))
               UC_INT:  cnt_o.intg = cnt_o.intg + CNT_W'(1);
               UC_LD:   cnt_o.ld   = cnt_o.ld   + CNT_W'(1);
               UC_ST:   cnt_o.st   = cnt_o.st   + CNT_W'(1);
               UC_FP:   cnt_o.fp   = cnt_o.fp   + CNT_W'(1);
               UC_BR:   cnt_o.br   = cnt_o.br   + CNT_W'(1);
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/igf_cap_check.sv
module igf_cap_check import igf_pkg::*; #(
   parameter int CAP_INT = 2,
   parameter int CAP_LD  = 2,
   parameter int CAP_ST  = 2,
   parameter int CAP_FP  = 4,
   parameter int CAP_BR  = 3
) (
   input  ucnt_t held_i,
   input  ucnt_t add_i,
   output logic  over_o
);
   function automatic logic exceeds(logic [CNT_W-1:0] a, logic [CNT_W-1:0] b, int cap);
      logic [CNT_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s > (CNT_W+1)'(cap);
   endfunction

   // R7: pairing two bundles must fit every unit class
   assign over_o = exceeds(held_i.intg, add_i.intg, CAP_INT)
                 | exceeds(held_i.ld,   add_i.ld,   CAP_LD)
                 | exceeds(held_i.st,   add_i.st,   CAP_ST)
                 | exceeds(held_i.fp,   add_i.fp,   CAP_FP)
                 | exceeds(held_i.br,   add_i.br,   CAP_BR);
endmodule

// File: rtl/igf_pack_ctrl.sv
module igf_pack_ctrl #(
   parameter int BUNDLE_W = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid_i,
   input  logic [BUNDLE_W-1:0] in_bundle_i,
   input  logic                in_eob_i,
   input  logic                over_i,
   input  logic                iss_ready_i,
   input  logic                b1_eob_i,
   output logic                in_ready_o,
   output logic                closed_o,
   output logic                split_o,
   output logic [1:0]          fill_o,
   output logic                ovf_o,
   output logic [BUNDLE_W-1:0] b0_o,
   output logic [BUNDLE_W-1:0] b1_o
);
   logic in_fire, out_fire;

   // R10: nothing enters while a packet waits or the issue side stalls
   assign in_ready_o = iss_ready_i && !closed_o;
   assign in_fire    = in_valid_i && in_ready_o;
   assign out_fire   = closed_o && iss_ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b0_o     <= '0;
         b1_o     <= '0;
         fill_o   <= 2'd0;
         closed_o <= 1'b0;
         split_o  <= 1'b0;
         ovf_o    <= 1'b0;
      end else begin
         ovf_o <= 1'b0;
         if (out_fire) begin
            if (split_o) begin
               // R7: carried bundle leads the next packet
               b0_o     <= b1_o;
               fill_o   <= 2'd1;
               closed_o <= b1_eob_i;
               split_o  <= 1'b0;
            end else begin
               fill_o   <= 2'd0;
               closed_o <= 1'b0;
            end
         end else if (in_fire) begin
            if (fill_o == 2'd0) begin
               b0_o     <= in_bundle_i;
               fill_o   <= 2'd1;
               closed_o <= in_eob_i;          // R4
            end else begin
               b1_o     <= in_bundle_i;
               fill_o   <= 2'd2;
               closed_o <= 1'b1;              // R6
               split_o  <= over_i;            // R7
               ovf_o    <= over_i;            // R8
            end
         end
      end
   end
endmodule

// File: rtl/igf_issue_former.sv
module igf_issue_former import igf_pkg::*; #(
   parameter int SLOTS        = 3,
   parameter int INSTR_W      = 41,
   parameter int TMPL_W       = 5,
   parameter int CLS_LSB      = 37,
   parameter int CLS_FW       = 4,
   parameter int EOB_BIT      = 0,
   parameter int ZERO_ILLEGAL = 1,
   parameter int CAP_INT      = 2,
   parameter int CAP_LD       = 2,
   parameter int CAP_ST       = 2,
   parameter int CAP_FP       = 4,
   parameter int CAP_BR       = 3,
   localparam int NB          = 2,
   localparam int BUNDLE_W    = TMPL_W + SLOTS*INSTR_W,
   localparam int LANES       = NB*SLOTS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [BUNDLE_W-1:0]      in_bundle,
   output logic                     iss_valid,
   input  logic                     iss_ready,
   output logic [LANES-1:0]         iss_lane_vld,
   output logic [LANES-1:0]         iss_lane_ill,
   output logic [LANES*INSTR_W-1:0] iss_instr,
   output logic [LANES*CLS_W-1:0]   iss_cls,
   output logic                     iss_grp_end,
   output logic                     cap_ovf
);
   if (CLS_LSB + CLS_FW > INSTR_W) begin : g_bad_cls
      $error("class field lies outside the instruction");
   end
   if (EOB_BIT >= TMPL_W) begin : g_bad_eob
      $error("group mark lies outside the template");
   end
   if ((1 << CLS_FW) <= NUM_CLS || CLS_FW < CLS_W) begin : g_bad_fw
      $error("class field too narrow");
   end
   if (LANES >= (1 << CNT_W)) begin : g_bad_cnt
      $error("unit counters too narrow for the lane count");
   end
   if (CAP_INT < 1 || CAP_LD < 1 || CAP_ST < 1 || CAP_FP < 1 || CAP_BR < 1) begin : g_bad_cap
      $error("every unit limit must be at least one");
   end

   logic                     in_eob;
   logic [SLOTS-1:0]         in_legal;
   logic [SLOTS*CLS_W-1:0]   in_cls;
   logic [SLOTS*INSTR_W-1:0] in_instr;
   ucnt_t                    in_cnt;
   logic                     over;
   logic                     closed, split;
   logic [1:0]               fill;
   logic [BUNDLE_W-1:0]      b0, b1;

   logic [BUNDLE_W-1:0]      pos_bundle [NB];
   logic [NB-1:0]            pos_eob;
   logic [SLOTS-1:0]         pos_legal  [NB];
   logic [SLOTS*CLS_W-1:0]   pos_cls    [NB];
   logic [SLOTS*INSTR_W-1:0] pos_instr  [NB];
   ucnt_t                    pos_cnt    [NB];
   logic [1:0]               iss_n;
   logic                     unused_dec;

   igf_bundle_decode #(
      .SLOTS(SLOTS), .INSTR_W(INSTR_W), .TMPL_W(TMPL_W), .CLS_LSB(CLS_LSB),
      .CLS_FW(CLS_FW), .EOB_BIT(EOB_BIT), .ZERO_ILLEGAL(ZERO_ILLEGAL)
   ) in_dec_i (
      .bundle_i(in_bundle), .eob_o(in_eob), .legal_o(in_legal),
      .cls_o(in_cls), .instr_o(in_instr), .cnt_o(in_cnt)
   );

   igf_cap_check #(
      .CAP_INT(CAP_INT), .CAP_LD(CAP_LD), .CAP_ST(CAP_ST), .CAP_FP(CAP_FP), .CAP_BR(CAP_BR)
   ) cap_i (
      .held_i(pos_cnt[0]), .add_i(in_cnt), .over_o(over)
   );

   igf_pack_ctrl #(.BUNDLE_W(BUNDLE_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_bundle_i(in_bundle),
      .in_eob_i(in_eob), .over_i(over), .iss_ready_i(iss_ready), .b1_eob_i(pos_eob[1]),
      .in_ready_o(in_ready), .closed_o(closed), .split_o(split), .fill_o(fill),
      .ovf_o(cap_ovf), .b0_o(b0), .b1_o(b1)
   );

   assign pos_bundle[0] = b0;
   assign pos_bundle[1] = b1;
   assign unused_dec = ^{in_legal, in_cls, in_instr, pos_cnt[1]};

   // R7/R9: a split packet shows only its first bundle
   assign iss_n = split ? 2'd1 : fill;

   for (genvar j = 0; j < NB; j++) begin : g_pos
      logic show;

      igf_bundle_decode #(
         .SLOTS(SLOTS), .INSTR_W(INSTR_W), .TMPL_W(TMPL_W), .CLS_LSB(CLS_LSB),
         .CLS_FW(CLS_FW), .EOB_BIT(EOB_BIT), .ZERO_ILLEGAL(ZERO_ILLEGAL)
      ) pos_dec_i (
         .bundle_i(pos_bundle[j]), .eob_o(pos_eob[j]), .legal_o(pos_legal[j]),
         .cls_o(pos_cls[j]), .instr_o(pos_instr[j]), .cnt_o(pos_cnt[j])
      );

      // R1/R6: bundle j occupies lanes j*SLOTS .. j*SLOTS+SLOTS-1
      assign show = closed && (2'(j) < iss_n);
      assign iss_lane_vld[j*SLOTS +: SLOTS]             = show ? pos_legal[j]  : '0;
      assign iss_lane_ill[j*SLOTS +: SLOTS]             = show ? ~pos_legal[j] : '0;
      assign iss_instr[j*SLOTS*INSTR_W +: SLOTS*INSTR_W] = show ? pos_instr[j]  : '0;
      assign iss_cls[j*SLOTS*CLS_W +: SLOTS*CLS_W]       = show ? pos_cls[j]    : '0;
   end

   assign iss_valid   = closed;
   // R4/R5: group ends only if the last bundle shown carries the mark
   assign iss_grp_end = closed && !split && ((fill == 2'd2) ? pos_eob[1] : pos_eob[0]);
endmodule

// File: rtl/igf_issue_former_chk.sv
module igf_issue_former_chk #(
   parameter int SLOTS   = 3,
   parameter int INSTR_W = 41,
   parameter int CLS_W   = 3,
   parameter int CAP_INT = 2,
   parameter int CAP_LD  = 2,
   parameter int CAP_ST  = 2,
   parameter int CAP_FP  = 4,
   parameter int CAP_BR  = 3,
   localparam int LANES  = 2*SLOTS
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_ready,
   input logic                     iss_valid,
   input logic                     iss_ready,
   input logic [LANES-1:0]         iss_lane_vld,
   input logic [LANES-1:0]         iss_lane_ill,
   input logic [LANES*INSTR_W-1:0] iss_instr,
   input logic [LANES*CLS_W-1:0]   iss_cls,
   input logic                     iss_grp_end,
   input logic                     cap_ovf
);
   int  n_int, n_ld, n_st, n_fp, n_br;
   logic upper_busy;

   always_comb begin
      n_int = 0; n_ld = 0; n_st = 0; n_fp = 0; n_br = 0;
      for (int l = 0; l < LANES; l++) begin
         if (iss_lane_vld[l]) begin
            case (int'(iss_cls[l*CLS_W +: CLS_W]))
               0: n_int++;
               1: n_ld++;
               2: n_st++;
               3: n_fp++;
               4: n_br++;
               default: ;
            endcase
         end
      end
   end

   assign upper_busy = |(iss_lane_vld[LANES-1:SLOTS] | iss_lane_ill[LANES-1:SLOTS]);

   p_ready_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_ready |-> !in_ready);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && !iss_ready |=> iss_valid && $stable(iss_instr) && $stable(iss_lane_vld)
                                  && $stable(iss_grp_end));

   p_lane_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_lane_vld & iss_lane_ill) == '0);

   p_cap_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && upper_busy |-> n_int <= CAP_INT && n_ld <= CAP_LD && n_st <= CAP_ST
                                  && n_fp <= CAP_FP && n_br <= CAP_BR);

   p_ovf_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ovf |=> !cap_ovf);

   p_ovf_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ovf |-> iss_valid && !iss_grp_end && !upper_busy);

   p_idle_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_valid |-> iss_lane_vld == '0 && iss_lane_ill == '0 && !iss_grp_end);

   p_reset_r11: assert property (@(posedge clk)
      !rst_n |=> !iss_valid && !cap_ovf);
endmodule

bind igf_issue_former igf_issue_former_chk chk_i (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .iss_valid(iss_valid),
   .iss_ready(iss_ready), .iss_lane_vld(iss_lane_vld), .iss_lane_ill(iss_lane_ill),
   .iss_instr(iss_instr), .iss_cls(iss_cls), .iss_grp_end(iss_grp_end), .cap_ovf(cap_ovf)
);

// File: tb/igf_issue_former_tb_top.sv
`timescale 1ns/1ps
module igf_issue_former_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_bundle = '0;
   logic         iss_valid;
   logic         iss_ready = 1'b0;
   logic [5:0]   iss_lane_vld, iss_lane_ill;
   logic [245:0] iss_instr;
   logic [17:0]  iss_cls;
   logic         iss_grp_end;
   logic         cap_ovf;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      logic [127:0] b0;
      logic [127:0] b1;
      int           nb;
      bit           ge;
   } pkt_t;

   pkt_t         exp_q[$];
   logic [127:0] m_b0 = '0;
   int           m_n = 0;

   always #10 clk = ~clk;

   igf_issue_former dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_bundle(in_bundle), .iss_valid(iss_valid), .iss_ready(iss_ready),
      .iss_lane_vld(iss_lane_vld), .iss_lane_ill(iss_lane_ill), .iss_instr(iss_instr),
      .iss_cls(iss_cls), .iss_grp_end(iss_grp_end), .cap_ovf(cap_ovf)
   );

   task automatic chk(bit ok, string tag, string what, logic [255:0] act, logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int cap_of(int k);
      case (k)
         3: return 4;
         4: return 3;
         default: return 2;
      endcase
   endfunction

   function automatic logic [3:0] slot_code(logic [127:0] b, int s);
      return b[5 + 41*s + 37 +: 4];
   endfunction

   function automatic int cls_count(logic [127:0] b, int k);
      int c = 0;
      for (int s = 0; s < 3; s++) if (slot_code(b, s) == 4'(k)) c++;
      return c;
   endfunction

   function automatic bit pair_over(logic [127:0] a, logic [127:0] b);
      for (int k = 0; k < 5; k++)
         if (cls_count(a, k) + cls_count(b, k) > cap_of(k)) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit solo_over(logic [127:0] a);
      for (int k = 0; k < 5; k++)
         if (cls_count(a, k) > cap_of(k)) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [127:0] mk(int c0, int c1, int c2, bit eob);
      logic [127:0] b;
      b = {$urandom, $urandom, $urandom, $urandom};
      b[5 + 0*41 + 37 +: 4] = 4'(c0);
      b[5 + 1*41 + 37 +: 4] = 4'(c1);
      b[5 + 2*41 + 37 +: 4] = 4'(c2);
      b[0] = eob;
      return b;
   endfunction

   function automatic int rnd_code();
      if ($urandom_range(0, 9) < 8) return int'($urandom_range(0, 4));
      return int'($urandom_range(5, 15));
   endfunction

   function automatic logic [127:0] rnd_bundle();
      return mk(rnd_code(), rnd_code(), rnd_code(), ($urandom_range(0, 9) < 4));
   endfunction

   function automatic pkt_t mkp(logic [127:0] a, logic [127:0] b, int nb, bit ge);
      pkt_t p;
      p.b0 = a; p.b1 = b; p.nb = nb; p.ge = ge;
      return p;
   endfunction

   // transaction-level model of group forming
   task automatic model_accept(logic [127:0] b, output bit split);
      split = 1'b0;
      if (m_n == 0) begin
         m_b0 = b; m_n = 1;
         if (b[0]) begin exp_q.push_back(mkp(b, '0, 1, 1'b1)); m_n = 0; end
      end else if (pair_over(m_b0, b)) begin
         split = 1'b1;
         exp_q.push_back(mkp(m_b0, '0, 1, 1'b0));
         m_b0 = b; m_n = 1;
         if (b[0]) begin exp_q.push_back(mkp(b, '0, 1, 1'b1)); m_n = 0; end
      end else begin
         exp_q.push_back(mkp(m_b0, b, 2, b[0]));
         m_n = 0;
      end
   endtask

   task automatic check_pkt(pkt_t p);
      logic [5:0]   ev, ei;
      logic [245:0] eins;
      logic [17:0]  ec;
      int           anb, ecnt;
      ev = '0; ei = '0; eins = '0; ec = '0;
      for (int l = 0; l < 6; l++) begin
         logic [127:0] bb;
         logic [3:0]   code;
         bb = (l / 3 == 0) ? p.b0 : p.b1;
         if (l / 3 < p.nb) begin
            code = slot_code(bb, l % 3);
            if (code < 4'd5) begin
               ev[l] = 1'b1;
               eins[l*41 +: 41] = bb[5 + 41*(l % 3) +: 41];
               ec[l*3 +: 3] = code[2:0];
            end else begin
               ei[l] = 1'b1;
            end
         end
      end
      chk(iss_instr == eins, "R1", "lane instructions", iss_instr, eins);
      chk(iss_cls == ec, "R2", "lane classes", iss_cls, ec);
      chk(iss_lane_vld == ev, "R3", "lane valid", iss_lane_vld, ev);
      chk(iss_lane_ill == ei, "R3", "lane illegal", iss_lane_ill, ei);
      chk(iss_grp_end == p.ge, "R4 R5", "group end", iss_grp_end, p.ge);
      anb = (|(iss_lane_vld[5:3] | iss_lane_ill[5:3])) ? 2 :
            ((|(iss_lane_vld[2:0] | iss_lane_ill[2:0])) ? 1 : 0);
      chk(anb == p.nb, "R6", "bundles in packet", anb, p.nb);
      if (p.nb == 2) begin
         for (int k = 0; k < 5; k++) begin
            ecnt = 0;
            for (int l = 0; l < 6; l++)
               if (iss_lane_vld[l] && iss_cls[l*3 +: 3] == 3'(k)) ecnt++;
            chk(ecnt <= cap_of(k), "R7", "class units in pair", ecnt, cap_of(k));
         end
      end
      if (p.nb == 1 && solo_over(p.b0))
         chk($countones(iss_lane_vld) == $countones(ev), "R9", "lone bundle issued whole",
             $countones(iss_lane_vld), $countones(ev));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R10 watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [127:0] dir [10];
      logic [127:0] cur;
      bit           have, fired, pend_ovf, drain;
      int           di;
      void'($urandom(32'd4242));
      dir[0] = mk(0, 1, 2, 1'b1);   // R4 single closed group
      dir[1] = mk(1, 1, 0, 1'b0);
      dir[2] = mk(1, 3, 3, 1'b1);   // R7/R8 three loads: split
      dir[3] = mk(3, 3, 4, 1'b0);   // R5 chain of four bundles
      dir[4] = mk(3, 3, 4, 1'b0);
      dir[5] = mk(0, 4, 2, 1'b0);
      dir[6] = mk(9, 15, 4, 1'b1);  // R3 illegal codes
      dir[7] = mk(0, 0, 0, 1'b1);   // R9 three integers alone
      dir[8] = mk(4, 4, 4, 1'b0);
      dir[9] = mk(4, 0, 0, 1'b1);   // R7/R8 four branches: split
      have = 0; fired = 0; pend_ovf = 0; drain = 0; di = 0; cur = '0;

      repeat (3) @(negedge clk);
      chk(iss_valid == 1'b0, "R11", "valid in reset", iss_valid, 0);
      chk(cap_ovf == 1'b0, "R11", "overflow in reset", cap_ovf, 0);
      rst_n = 1'b1;
      iss_ready = 1'b1;
      #1;
      chk(in_ready == 1'b1, "R11", "ready after reset", in_ready, 1);

      for (int cyc = 0; cyc < 4020; cyc++) begin
         @(negedge clk);
         chk(cap_ovf == pend_ovf, "R8", "overflow pulse", cap_ovf, pend_ovf);
         drain = (cyc >= 4000);
         if (fired) have = 0;
         if (!have && !drain) begin
            if (di < 10) begin
               cur = dir[di]; di++; have = 1;
            end else if ($urandom_range(0, 3) != 0) begin
               cur = rnd_bundle(); have = 1;
            end
         end
         in_valid  = have;
         in_bundle = cur;
         iss_ready = (cyc < 40 || drain) ? 1'b1 : ($urandom_range(0, 3) != 0);
         #1;
         chk(iss_valid == (exp_q.size() != 0), "R10", "packet waiting", iss_valid, exp_q.size() != 0);
         chk(in_ready == (iss_ready && exp_q.size() == 0), "R10", "input ready",
             in_ready, iss_ready && exp_q.size() == 0);
         if (iss_valid && iss_ready && exp_q.size() != 0) begin
            check_pkt(exp_q[0]);
            void'(exp_q.pop_front());
         end
         fired = in_valid && in_ready;
         if (fired) model_accept(cur, pend_ovf);
         else pend_ovf = 1'b0;
      end
      chk(exp_q.size() == 0, "R10", "packets left undelivered", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule